// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block sits between an on-chip host and an external 32K-by-8 asynchronous static RAM. The host raises single-beat read or write requests on a valid/ready port. The controller turns each request into a timed sequence of active-low chip-select, write-enable and output-enable strobes, together with a 15-bit address and an 8-bit data bus. The data bus appears as separate output, drive-enable and input signals, which the pad ring merges into one bidirectional bus.

Every analog timing limit of the memory is held as a nanosecond parameter. Each one becomes a whole number of clock cycles by rounding up against a clock-period parameter, and every strobe phase lasts at least one cycle. Writes are controlled by write-enable. The bus has a turnaround gap after each read, so the controller never drives data while the memory may still be driving.

A retention input parks the memory deselected in a low-power state. When retention is released, the host port stays closed for a recovery interval of millisecond scale.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` and `rd_valid` are 0, and `host_ready` is 1 once reset is released while `ret_req` is 0.
- R2: Only three strobe combinations appear. Idle/deselect has all strobes at 1. Write has `mem_cs_n`=0, `mem_we_n`=0 and `mem_oe_n`=1. Read has `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1.
- R3: A write holds `mem_we_n` and `mem_cs_n` low together for exactly ceil(max(tWP,tCW,tAW,tDW)/Tclk) consecutive cycles. This is 6 cycles at the default parameters.
- R4: `mem_addr` takes the new request address one cycle before any strobe falls, and it does not change while `mem_cs_n` is 0.
- R5: `mem_dq_oe` is 1 exactly while `mem_we_n` is 0, and never while `mem_oe_n` is 0. During that window `mem_dq_o` carries the host's write data.
- R6: A read holds `mem_oe_n` low for ceil(max(tAA,tACS,tOE)/Tclk) cycles (7 at default). The bus value is captured on the edge that ends this window, and `rd_valid` is 1 for exactly one cycle with that value on `rd_data`.
- R7: After `mem_oe_n` rises, `mem_dq_oe` stays 0 for at least ceil(tHZ/Tclk) cycles (3 at default). The controller also leaves the strobes high long enough to meet the read cycle time.
- R8: `host_ready` is 1 only while no access, turnaround or recovery is in progress and `ret_req` is 0. All strobes are high whenever it is 1, and a request is accepted only on a cycle with `host_valid` and `host_ready` both 1.
- R9: While `ret_req` is 1 and no access is in progress, `mem_cs_n` stays 1 and `host_ready` stays 0. A request offered then is ignored and leaves the memory contents unchanged.
- R10: `ret_req` raised during an access lets that access finish first. After `ret_req` falls, `host_ready` stays 0 for ceil(tRECOV/Tclk) cycles counted from the first edge that sees it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Request offered |
| host_ready | output | 1 | Request can be accepted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Request address |
| host_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Captured read data |
| ret_req | input | 1 | Level request for retention mode |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data from memory |

## Verification
The assertions assume that reset starts the run, and that the host holds `host_addr`, `host_we` and `host_wdata` steady while `host_valid` waits for `host_ready`. The bench drives requests only at falling edges and keeps them until the accepting edge. It then drops `host_valid` at once, so no request is ever retracted or changed while it is pending.

The bench's memory model returns a poison byte until the access time has elapsed, so any capture that comes too early shows up as wrong data. Random reads and writes use a small address pool, which makes reads hit earlier writes. Retention is raised both while idle and in the middle of a write.

// File: rtl/sram_ctrl_pkg.sv
// Shared phase encoding and nanosecond-to-cycle conversion for the SRAM controller.
// Assumes all timing parameters are non-negative integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WREC   = 3'd3,
        PH_RACC   = 3'd4,
        PH_RTURN  = 3'd5,
        PH_RET    = 3'd6,
        PH_RECOV  = 3'd7
    } phase_t;

    // Round ns up to whole clock cycles, never less than one.
    function automatic int ns2cyc(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one strobe phase. A load sets the count; done is
// high while the count is zero. Assumes load values fit CW bits.
module sram_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
// Phase sequencer: walks each access through address, strobe and recovery
// phases, and handles retention entry and exit. Phase lengths are in cycles
// (each >= 1). Assumes the timer reports done one cycle after a load of 0.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CW        = 8,
    parameter int WP_CYC    = 6,
    parameter int WREC_CYC  = 1,
    parameter int ACC_CYC   = 7,
    parameter int TURN_CYC  = 3,
    parameter int RECOV_CYC = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic          ret_req,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output phase_t        phase_d,
    output logic          accept,
    output logic          capture,
    output logic          ready
);
    phase_t state_q;
    logic   is_wr_q;

    assign ready   = (state_q == PH_IDLE) && !ret_req;
    assign accept  = ready && req_valid;
    assign capture = (state_q == PH_RACC) && tmr_done;

    // Next phase and timer load for each phase.
    always_comb begin
        phase_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            PH_IDLE: begin
                if (ret_req)        phase_d = PH_RET;
                else if (req_valid) phase_d = PH_ADDR;
            end
            PH_ADDR: begin
                tmr_load = 1'b1;
                if (is_wr_q) begin
                    phase_d = PH_WPULSE;
                    tmr_val = CW'(WP_CYC - 1);
                end else begin
                    phase_d = PH_RACC;
                    tmr_val = CW'(ACC_CYC - 1);
                end
            end
            PH_WPULSE: if (tmr_done) begin
                phase_d  = PH_WREC;
                tmr_load = 1'b1;
                tmr_val  = CW'(WREC_CYC - 1);
            end
            PH_WREC:  if (tmr_done) phase_d = PH_IDLE;
            PH_RACC: if (tmr_done) begin
                phase_d  = PH_RTURN;
                tmr_load = 1'b1;
                tmr_val  = CW'(TURN_CYC - 1);
            end
            PH_RTURN: if (tmr_done) phase_d = PH_IDLE;
            PH_RET: if (!ret_req) begin
                phase_d  = PH_RECOV;
                tmr_load = 1'b1;
                tmr_val  = CW'(RECOV_CYC - 1);
            end
            PH_RECOV: begin
                if (ret_req)       phase_d = PH_RET;
                else if (tmr_done) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register and latched access direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            is_wr_q <= 1'b0;
        end else begin
            state_q <= phase_d;
            if (accept) is_wr_q <= req_we;
        end
    end
endmodule

// File: rtl/sram_bus_path.sv
// Registered memory-side outputs: address/data latches, strobes decoded from
// the next phase so they change glitch-free on a clock edge, and read capture.
// Assumes mem_dq_i is settled at the capture edge.
module sram_bus_path
    import sram_ctrl_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  phase_t        phase_d,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] mem_dq_i,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic wr_ph, rd_ph;
    assign wr_ph = (phase_d == PH_WPULSE);
    assign rd_ph = (phase_d == PH_RACC);

    // Strobes and drive enable, all high/off in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= !(wr_ph || rd_ph);
            mem_we_n  <= !wr_ph;
            mem_oe_n  <= !rd_ph;
            mem_dq_oe <= wr_ph;
        end
    end

    // Latch address and write data when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= host_addr;
            mem_dq_o <= host_wdata;
        end
    end

    // Capture read data on the edge that closes the access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= mem_dq_i;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the asynchronous SRAM controller: converts nanosecond limits into
// cycle counts and connects sequencer, phase timer and bus path.
// Assumes the host holds request fields steady while valid waits for ready.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW          = 15,
    parameter int DW          = 8,
    parameter int CLK_NS      = 10,
    parameter int T_WC_NS     = 70,
    parameter int T_WP_NS     = 55,
    parameter int T_CW_NS     = 50,
    parameter int T_AW_NS     = 50,
    parameter int T_DW_NS     = 30,
    parameter int T_RC_NS     = 70,
    parameter int T_AA_NS     = 70,
    parameter int T_ACS_NS    = 70,
    parameter int T_OE_NS     = 35,
    parameter int T_HZ_NS     = 30,
    parameter int T_RECOV_NS  = 5_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_valid,
    output logic          host_ready,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          ret_req,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int WP_CYC    = ns2cyc(imax(imax(T_WP_NS, T_CW_NS), imax(T_AW_NS, T_DW_NS)), CLK_NS);
    localparam int WC_CYC    = ns2cyc(T_WC_NS, CLK_NS);
    localparam int WREC_CYC  = imax(1, WC_CYC - WP_CYC - 1);
    localparam int ACC_CYC   = ns2cyc(imax(imax(T_AA_NS, T_ACS_NS), T_OE_NS), CLK_NS);
    localparam int RC_CYC    = ns2cyc(T_RC_NS, CLK_NS);
    localparam int HZ_CYC    = ns2cyc(T_HZ_NS, CLK_NS);
    localparam int TURN_CYC  = imax(HZ_CYC, imax(1, RC_CYC - ACC_CYC - 1));
    localparam int RECOV_CYC = ns2cyc(T_RECOV_NS, CLK_NS);
    localparam int CW        = $clog2(RECOV_CYC + ACC_CYC + WP_CYC + TURN_CYC + 1);

    logic          tmr_load, tmr_done, accept, capture;
    logic [CW-1:0] tmr_val;
    phase_t        phase_d;

    sram_seq_fsm #(
        .CW(CW), .WP_CYC(WP_CYC), .WREC_CYC(WREC_CYC), .ACC_CYC(ACC_CYC),
        .TURN_CYC(TURN_CYC), .RECOV_CYC(RECOV_CYC)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .req_valid(host_valid), .req_we(host_we),
        .ret_req(ret_req), .tmr_done(tmr_done), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .phase_d(phase_d), .accept(accept),
        .capture(capture), .ready(host_ready)
    );

    sram_phase_timer #(.CW(CW)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .done(tmr_done)
    );

    sram_bus_path #(.AW(AW), .DW(DW)) bus_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .phase_d(phase_d), .host_addr(host_addr), .host_wdata(host_wdata),
        .mem_dq_i(mem_dq_i), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
// Property checker for the SRAM controller, bound to every instance.
// Assumes a synchronous reset at the start of the run.
module sram_async_ctrl_chk #(
    parameter int AW     = 15,
    parameter int WP_CYC = 6,
    parameter int HZ_CYC = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_cs_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe,
    input logic [AW-1:0] mem_addr,
    input logic          rd_valid,
    input logic          host_ready
);
    logic [7:0] we_low_cnt, oe_high_cnt;

    // Count consecutive write-enable-low cycles and output-enable-high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt  <= '0;
            oe_high_cnt <= 8'(HZ_CYC);
        end else begin
            we_low_cnt  <= !mem_we_n ? ((we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 1'b1) : '0;
            oe_high_cnt <= !mem_oe_n ? '0 : ((oe_high_cnt == 8'hFF) ? oe_high_cnt : oe_high_cnt + 1'b1);
        end
    end

    AST_NO_WE_OE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));                                               // R2
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> !mem_cs_n);                                  // R2
    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == 8'(WP_CYC)));                          // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));                   // R4
    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_cs_n && mem_oe_n));                      // R5
    AST_RDVALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                                                  // R6
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (oe_high_cnt >= 8'(HZ_CYC)));                               // R7
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));                       // R8
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .WP_CYC(WP_CYC), .HZ_CYC(HZ_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr),
    .rd_valid(rd_valid), .host_ready(host_ready)
);

// File: tb/sram_async_ctrl_tb.sv
// Bench: directed corners plus seeded random traffic against a behavioural
// SRAM model that returns a poison byte until the access time has passed.
module sram_async_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WP_EXP     = 6;
    localparam int ACC_EXP    = 7;
    localparam int HZ_EXP     = 3;
    localparam int RECOV_EXP  = 50;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_valid = 1'b0, host_we = 1'b0, ret_req = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic host_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0] rd_data, mem_dq_o, mem_dq_i;
    logic [14:0] mem_addr;

    int checks = 0, errors = 0;
    logic [7:0] model_mem [int];
    logic [7:0] exp_mem   [int];
    int rd_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl #(.CLK_NS(CLK_PERIOD), .T_RECOV_NS(500)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ret_req(ret_req),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    function automatic logic [7:0] init_val(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] exp_read(input logic [14:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_val(a);
    endfunction

    function automatic logic [7:0] model_rd(input logic [14:0] a);
        return model_mem.exists(int'(a)) ? model_mem[int'(a)] : init_val(a);
    endfunction

    // Memory model: write on strobe overlap, data valid only after access time.
    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) model_mem[int'(mem_addr)] = mem_dq_o;
        rd_cnt <= (!mem_cs_n && !mem_oe_n && mem_we_n) ? rd_cnt + 1 : 0;
    end
    assign mem_dq_i = (rd_cnt >= ACC_EXP - 1) ? model_rd(mem_addr) : 8'hEE;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Interface monitors sampled on the falling edge.
    int we_run = 0, oe_run = 0, since_oe = 100;
    logic prev_cs_n = 1'b1, prev_dq_oe = 1'b0;
    logic [14:0] prev_addr = '0;
    logic [7:0]  cur_wdata = '0;
    always @(negedge clk) if (rst_n) begin
        if (!mem_we_n) we_run++;
        else if (we_run != 0) begin chk(we_run == WP_EXP, "R3 we width", we_run, WP_EXP); we_run = 0; end
        if (!mem_oe_n) oe_run++;
        else if (oe_run != 0) begin chk(oe_run == ACC_EXP, "R6 oe width", oe_run, ACC_EXP); oe_run = 0; end
        if (!(mem_cs_n && mem_we_n && mem_oe_n))
            chk(!mem_cs_n && (mem_we_n != mem_oe_n), "R2 strobe code",
                {mem_cs_n, mem_we_n, mem_oe_n}, 0);
        if (!mem_cs_n && !prev_cs_n) chk(mem_addr == prev_addr, "R4 addr moved", mem_addr, prev_addr);
        if (mem_dq_oe != !mem_we_n) chk(1'b0, "R5 drive window", mem_dq_oe, !mem_we_n);
        if (mem_dq_oe) chk(mem_dq_o == cur_wdata, "R5 write data", mem_dq_o, cur_wdata);
        if (mem_dq_oe && !prev_dq_oe) chk(since_oe >= HZ_EXP, "R7 turnaround", since_oe, HZ_EXP);
        if (host_ready) chk(mem_cs_n && mem_we_n && mem_oe_n, "R8 ready while busy", mem_cs_n, 1);
        since_oe = !mem_oe_n ? 0 : since_oe + 1;
        prev_cs_n = mem_cs_n; prev_addr = mem_addr; prev_dq_oe = mem_dq_oe;
    end

    task automatic issue(input logic we, input logic [14:0] a, input logic [7:0] d);
        int w = 0;
        @(negedge clk);
        while (!host_ready && w < 1000) begin @(negedge clk); w++; end
        host_valid = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        if (we) begin cur_wdata = d; exp_mem[int'(a)] = d; end
        @(negedge clk);
        host_valid = 1'b0;
        if (we) begin
            chk(host_ready == 1'b0, "R8 busy after accept", host_ready, 0);
            chk(mem_addr == a && mem_cs_n, "R4 addr before strobe", mem_addr, a);
        end
    endtask

    task automatic do_read(input logic [14:0] a, input string tag);
        int w = 0;
        issue(1'b0, a, 8'h00);
        while (!rd_valid && w < 100) begin @(negedge clk); w++; end
        chk(rd_valid && rd_data == exp_read(a), tag, rd_data, exp_read(a));
        @(negedge clk);
        chk(!rd_valid, "R6 rd_valid one cycle", rd_valid, 0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lows;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid, "R1 reset outputs",
            {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'he);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready == 1'b1, "R1 ready after reset", host_ready, 1);

        // Directed: unwritten read, write, readback, address extremes.
        do_read(15'h0123, "R6 read init data");
        issue(1'b1, 15'h0000, 8'hA5);
        do_read(15'h0000, "R6 readback low addr");
        issue(1'b1, 15'h7FFF, 8'h3C);
        do_read(15'h7FFF, "R6 readback top addr");
        // Read directly followed by write exercises the turnaround (R7).
        do_read(15'h0000, "R7 read before write");
        issue(1'b1, 15'h0001, 8'hFF);
        do_read(15'h0001, "R5 readback after turnaround");

        // Retention while idle with a request pending: ignored (R9), recovery (R10).
        @(negedge clk); ret_req = 1'b1;
        host_valid = 1'b1; host_we = 1'b1; host_addr = 15'h0000; host_wdata = 8'h77;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(mem_cs_n && !host_ready, "R9 deselected in retention", {mem_cs_n, host_ready}, 2);
        end
        host_valid = 1'b0;
        ret_req = 1'b0;
        lows = 0;
        @(negedge clk);
        while (!host_ready && lows < 500) begin lows++; @(negedge clk); end
        chk(lows == RECOV_EXP, "R10 recovery length", lows, RECOV_EXP);
        do_read(15'h0000, "R9 ignored write left data");

        // Retention raised mid-write: the write finishes first.
        issue(1'b1, 15'h0042, 8'h99);
        ret_req = 1'b1;
        repeat (12) @(negedge clk);
        chk(mem_cs_n && !host_ready, "R10 retention after write", {mem_cs_n, host_ready}, 2);
        ret_req = 1'b0;
        do_read(15'h0042, "R10 write completed before retention");

        // Seeded random traffic over a small pool.
        for (int n = 0; n < 80; n++) begin
            logic [14:0] a;
            a = 15'(($urandom % 8) * 15'h0F0F);
            if ($urandom % 2) issue(1'b1, a, 8'($urandom));
            else do_read(a, "R6 random read");
        end
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule